// File: doc/BRIEF.md
# Boot Region Lockout Controller

This block guards the two boot regions of a 128K x 8 memory that is programmed one 128-byte sector at a time. The bottom 8 KB and the top 8 KB of the address space can each be locked on their own. A lock is set by a seven-write command sequence on the write bus, and it can never be cleared by the bus. The block watches every write strobe. It steps through the command sequences, holds the two lock bits, and answers each sector program request with a one-cycle grant or deny pulse.

The same write bus carries a six-write whole-device erase command. The erase is refused whenever either region is locked. The two lock sequences and the erase sequence begin with the same five writes, and the sixth write decides which one is meant. The lock bits normally live in nonvolatile cells. Here, two preset inputs stand in for those cells: holding a preset high sets its lock bit, as a memory that was locked before power-up would be.

Top module: `boot_lock_ctrl`

## Requirements
- R1: After reset with both preset inputs low, `lock_lo` and `lock_hi` read 0 and no grant or deny pulse is present.
- R2: A lock bit is set in the first cycle after internal reset release in which its preset input is high. Once set, it stays set until the next reset, whatever the preset input or the bus then does.
- R3: The lock sequence is seven bus writes, with addresses and data in hex: 5555/AA, 2AAA/55, 5555/80, 5555/AA, 2AAA/55, 5555/40, and then a final write of data 00. If the final write's address has bits 16..13 all 0, `lock_lo` is set. If those bits are all 1, `lock_hi` is set. Any other address sets nothing. The lock output changes after the clock edge that samples the final write.
- R4: Each cycle with `prog_req` high produces exactly one of `prog_grant` or `prog_deny`, high for the single following cycle only.
- R5: The program sector number is address bits 16..7. Sectors 0..63 form the low region and sectors 960..1023 form the high region. A request is denied exactly when its sector lies in a locked region.
- R6: A write that does not match the expected step returns the sequence to idle, and the following writes are matched from the first step. A final lock write with data other than 00 locks nothing.
- R7: The erase sequence is the first five lock-sequence writes followed by 5555/10. On the cycle after the sixth write, `erase_grant` pulses if neither region is locked, and `erase_deny` pulses otherwise.
- R8: Locking one region leaves requests for sectors outside it granted, including the sectors next to its boundary.
- R9: Cycles with `wr_en` low neither advance nor abort a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nv_lock_lo | input | 1 | Retained lock state of the low region |
| nv_lock_hi | input | 1 | Retained lock state of the high region |
| wr_en | input | 1 | Write strobe event, one per cycle |
| wr_addr | input | 17 | Byte address of the write |
| wr_data | input | 8 | Data of the write |
| prog_req | input | 1 | Sector program request |
| prog_sector | input | 10 | Sector targeted by the request |
| prog_grant | output | 1 | Request permitted |
| prog_deny | output | 1 | Request refused |
| erase_grant | output | 1 | Whole-device erase permitted |
| erase_deny | output | 1 | Whole-device erase refused |
| lock_lo | output | 1 | Low region locked |
| lock_hi | output | 1 | High region locked |

## Verification
The bench builds the block with its default parameters: a 17-bit address, 128-byte sectors, a 4-bit region field, and a two-stage reset synchronizer. These values give 1024 sectors and 64-sector regions. With them, the region edge sectors 63/64 and 959/960 and a final lock address between the two regions can all be reached directly. Short sequences are enough to test aborts, idle gaps and erase refusal under a lock.

// File: rtl/bll_pkg.sv
`timescale 1ns / 1ps
package bll_pkg;
  localparam int NUM_REGIONS = 2;
  localparam int REG_LO      = 0;
  localparam int REG_HI      = 1;

  // command data values
  localparam logic [7:0] KD_OPEN  = 8'hAA;
  localparam logic [7:0] KD_CONF  = 8'h55;
  localparam logic [7:0] KD_EXT   = 8'h80;
  localparam logic [7:0] KD_LOCK  = 8'h40;
  localparam logic [7:0] KD_ERASE = 8'h10;
  localparam logic [7:0] KD_PICK  = 8'h00;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_K1, SQ_K2, SQ_K3, SQ_K4, SQ_K5, SQ_SEL
  } seq_st_e;

  typedef struct packed {
    logic pg;
    logic pd;
    logic eg;
    logic ed;
  } rsp_t;
endpackage

// File: rtl/bll_rst_sync.sv
`timescale 1ns / 1ps
module bll_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/bll_region_match.sv
`timescale 1ns / 1ps
module bll_region_match
  import bll_pkg::*;
#(
  parameter int IN_W     = 17,
  parameter int REGION_W = 4
) (
  input  logic [IN_W-1:0]        val_i,
  output logic [NUM_REGIONS-1:0] hit_o
);
  localparam int SPAN_W = IN_W - REGION_W;
  localparam logic [IN_W-1:0] SPAN = IN_W'(1) << SPAN_W;

  // region 0 sits at the bottom, region 1 at the top of the range
  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_reg
    localparam logic [IN_W-1:0] BASE = (r == 0) ? '0 : (~SPAN + IN_W'(1));
    logic [IN_W-1:0] off;
    assign off      = val_i - BASE;
    assign hit_o[r] = (off < SPAN);
  end
endmodule

// File: rtl/bll_cmd_seq.sv
`timescale 1ns / 1ps
module bll_cmd_seq
  import bll_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR_A = ADDR_W'(32'h5555),
  parameter logic [ADDR_W-1:0] KEY_ADDR_B = ADDR_W'(32'h2AAA)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en_i,
  input  logic [ADDR_W-1:0]      wr_addr_i,
  input  logic [DATA_W-1:0]      wr_data_i,
  input  logic [NUM_REGIONS-1:0] region_hit_i,
  output logic [NUM_REGIONS-1:0] lock_set_o,
  output logic                   erase_cmd_o
);
  localparam logic [DATA_W-1:0] D_OPEN  = DATA_W'(KD_OPEN);
  localparam logic [DATA_W-1:0] D_CONF  = DATA_W'(KD_CONF);
  localparam logic [DATA_W-1:0] D_EXT   = DATA_W'(KD_EXT);
  localparam logic [DATA_W-1:0] D_LOCK  = DATA_W'(KD_LOCK);
  localparam logic [DATA_W-1:0] D_ERASE = DATA_W'(KD_ERASE);
  localparam logic [DATA_W-1:0] D_PICK  = DATA_W'(KD_PICK);

  seq_st_e st_q, st_d;
  logic    at_a, at_b;

  always_comb begin
    at_a = (wr_addr_i == KEY_ADDR_A);
    at_b = (wr_addr_i == KEY_ADDR_B);
  end

  // next state; any mismatch falls back to idle
  always_comb begin
    st_d        = st_q;
    lock_set_o  = '0;
    erase_cmd_o = 1'b0;
    if (wr_en_i) begin
      st_d = SQ_IDLE;
      case (st_q)
        SQ_IDLE: if (at_a && wr_data_i == D_OPEN) st_d = SQ_K1;
        SQ_K1:   if (at_b && wr_data_i == D_CONF) st_d = SQ_K2;
        SQ_K2:   if (at_a && wr_data_i == D_EXT)  st_d = SQ_K3;
        SQ_K3:   if (at_a && wr_data_i == D_OPEN) st_d = SQ_K4;
        SQ_K4:   if (at_b && wr_data_i == D_CONF) st_d = SQ_K5;
        SQ_K5: begin
          if (at_a && wr_data_i == D_LOCK)       st_d = SQ_SEL;
          else if (at_a && wr_data_i == D_ERASE) erase_cmd_o = 1'b1;
        end
        SQ_SEL:  if (wr_data_i == D_PICK) lock_set_o = region_hit_i;
        default: st_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       st_q <= SQ_IDLE;
    else if (wr_en_i) st_q <= st_d;
  end
endmodule

// File: rtl/bll_lock_bank.sv
`timescale 1ns / 1ps
module bll_lock_bank #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] nv_i,
  output logic [N-1:0] lock_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic q_r, d_c, en_c;

    always_comb begin
      d_c  = q_r | set_i[g] | nv_i[g];
      en_c = d_c ^ q_r;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q_r <= 1'b0;
      else if (en_c) q_r <= d_c;
    end

    assign lock_o[g] = q_r;
  end
endmodule

// File: rtl/boot_lock_ctrl.sv
`timescale 1ns / 1ps
module boot_lock_ctrl
  import bll_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int DATA_W      = 8,
  parameter int SECT_BYTE_W = 7,
  parameter int REGION_W    = 4,
  parameter int RST_STAGES  = 2,
  parameter logic [ADDR_W-1:0] KEY_ADDR_A = ADDR_W'(32'h5555),
  parameter logic [ADDR_W-1:0] KEY_ADDR_B = ADDR_W'(32'h2AAA),
  localparam int SECT_W = ADDR_W - SECT_BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nv_lock_lo,
  input  logic              nv_lock_hi,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              prog_req,
  input  logic [SECT_W-1:0] prog_sector,
  output logic              prog_grant,
  output logic              prog_deny,
  output logic              erase_grant,
  output logic              erase_deny,
  output logic              lock_lo,
  output logic              lock_hi
);
  logic                   rst_int_n;
  logic [NUM_REGIONS-1:0] wr_hit, sect_hit, lock_set, lock_q, nv_vec;
  logic                   erase_cmd, sect_blocked, any_lock;
  rsp_t                   rsp_d, rsp_q;

  bll_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  bll_region_match #(.IN_W(ADDR_W), .REGION_W(REGION_W)) u_wr_match (
    .val_i(wr_addr), .hit_o(wr_hit)
  );

  bll_region_match #(.IN_W(SECT_W), .REGION_W(REGION_W)) u_sect_match (
    .val_i(prog_sector), .hit_o(sect_hit)
  );

  bll_cmd_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .KEY_ADDR_A(KEY_ADDR_A), .KEY_ADDR_B(KEY_ADDR_B)
  ) u_seq (
    .clk(clk), .rst_n(rst_int_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .region_hit_i(wr_hit), .lock_set_o(lock_set),
    .erase_cmd_o(erase_cmd)
  );

  always_comb begin
    nv_vec         = '0;
    nv_vec[REG_LO] = nv_lock_lo;
    nv_vec[REG_HI] = nv_lock_hi;
  end

  bll_lock_bank #(.N(NUM_REGIONS)) u_locks (
    .clk(clk), .rst_n(rst_int_n), .set_i(lock_set), .nv_i(nv_vec),
    .lock_o(lock_q)
  );

  // decisions use the lock state held before the edge
  always_comb begin
    sect_blocked = |(sect_hit & lock_q);
    any_lock     = |lock_q;
    rsp_d.pg     = prog_req & ~sect_blocked;
    rsp_d.pd     = prog_req &  sect_blocked;
    rsp_d.eg     = erase_cmd & ~any_lock;
    rsp_d.ed     = erase_cmd &  any_lock;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) rsp_q <= '0;
    else            rsp_q <= rsp_d;
  end

  assign prog_grant  = rsp_q.pg;
  assign prog_deny   = rsp_q.pd;
  assign erase_grant = rsp_q.eg;
  assign erase_deny  = rsp_q.ed;
  assign lock_lo     = lock_q[REG_LO];
  assign lock_hi     = lock_q[REG_HI];
endmodule

// File: rtl/bll_lock_chk.sv
`timescale 1ns / 1ps
module bll_lock_chk (
  input logic clk,
  input logic rst_n,
  input logic prog_req,
  input logic prog_grant,
  input logic prog_deny,
  input logic erase_grant,
  input logic erase_deny,
  input logic lock_lo,
  input logic lock_hi
);
  a_r2_lo_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(lock_lo));
  a_r2_hi_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(lock_hi));
  a_r4_single_answer: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_grant && prog_deny));
  a_r4_answer_has_req: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_grant || prog_deny) |-> $past(prog_req));
  a_r5_deny_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
    prog_deny |-> (lock_lo || lock_hi));
  a_r7_erase_single: assert property (@(posedge clk) disable iff (!rst_n)
    !(erase_grant && erase_deny));
  a_r7_erase_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    erase_grant |-> (!$past(lock_lo) && !$past(lock_hi)));
endmodule

bind boot_lock_ctrl bll_lock_chk u_chk (
  .clk(clk), .rst_n(rst_n), .prog_req(prog_req), .prog_grant(prog_grant),
  .prog_deny(prog_deny), .erase_grant(erase_grant), .erase_deny(erase_deny),
  .lock_lo(lock_lo), .lock_hi(lock_hi)
);

// File: tb/boot_lock_ctrl_test.sv
`timescale 1ns / 1ps
module boot_lock_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n, nv_lock_lo, nv_lock_hi, wr_en, prog_req;
  logic [16:0] wr_addr;
  logic [7:0]  wr_data;
  logic [9:0]  prog_sector;
  logic        prog_grant, prog_deny, erase_grant, erase_deny, lock_lo, lock_hi;
  int          n_chk = 0;
  int          n_fail = 0;

  always #2.5 clk = ~clk;

  boot_lock_ctrl uut (
    .clk(clk), .rst_n(rst_n), .nv_lock_lo(nv_lock_lo), .nv_lock_hi(nv_lock_hi),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .prog_req(prog_req),
    .prog_sector(prog_sector), .prog_grant(prog_grant), .prog_deny(prog_deny),
    .erase_grant(erase_grant), .erase_deny(erase_deny), .lock_lo(lock_lo),
    .lock_hi(lock_hi)
  );

  // expected flags: {prog_grant, prog_deny, erase_grant, erase_deny, lock_lo, lock_hi}
  typedef struct packed {
    logic        we;
    logic [16:0] a;
    logic [7:0]  d;
    logic        pr;
    logic [9:0]  sec;
    logic [5:0]  ex;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 57;
  localparam vec_t VECS [NV] = '{
    {1'b0, 17'h00000, 8'h00, 1'b1, 10'd0,    6'b100000, 4'd4}, // R4 low sector granted
    {1'b0, 17'h00000, 8'h00, 1'b1, 10'd1023, 6'b100000, 4'd4}, // R4 top sector granted
    {1'b1, 17'h05555, 8'hAA, 1'b0, 10'd0,    6'b000000, 4'd7}, // R7 erase
    {1'b1, 17'h02AAA, 8'h55, 1'b0, 10'd0,    6'b000000, 4'd7},
    {1'b1, 17'h05555, 8'h80, 1'b0, 10'd0,    6'b000000, 4'd7},
    {1'b1, 17'h05555, 8'hAA, 1'b0, 10'd0,    6'b000000, 4'd7},
    {1'b1, 17'h02AAA, 8'h55, 1'b0, 10'd0,    6'b000000, 4'd7},
    {1'b1, 17'h05555, 8'h10, 1'b0, 10'd0,    6'b001000, 4'd7}, // R7 granted, unlocked
    {1'b1, 17'h05555, 8'hAA, 1'b0, 10'd0,    6'b000000, 4'd6}, // R6 abort
    {1'b1, 17'h02AAA, 8'h55, 1'b0, 10'd0,    6'b000000, 4'd6},
    {1'b1, 17'h05555, 8'h81, 1'b0, 10'd0,    6'b000000, 4'd6},
    {1'b1, 17'h05555, 8'hAA, 1'b0, 10'd0,    6'b000000, 4'd6},
    {1'b1, 17'h02AAA, 8'h55, 1'b0, 10'd0,    6'b000000, 4'd6},
    {1'b1, 17'h05555, 8'h10, 1'b0, 10'd0,    6'b000000, 4'd6}, // R6 no erase
    {1'b1, 17'h05555, 8'hAA, 1'b0, 10'd0,    6'b000000, 4'd9}, // R9 gaps
    {1'b0, 17'h00000, 8'h00, 1'b0, 10'd0,    6'b000000, 4'd9},
    {1'b1, 17'h02AAA, 8'h55, 1'b0, 10'd0,    6'b000000, 4'd9},
    {1'b1, 17'h05555, 8'h80, 1'b0, 10'd0,    6'b000000, 4'd9},
    {1'b0, 17'h00000, 8'h00, 1'b0, 10'd0,    6'b000000, 4'd9},
    {1'b1, 17'h05555, 8'hAA, 1'b0, 10'd0,    6'b000000, 4'd9},
    {1'b1, 17'h02AAA, 8'h55, 1'b0, 10'd0,    6'b000000, 4'd9},
    {1'b1, 17'h05555, 8'h40, 1'b0, 10'd0,    6'b000000, 4'd9},
    {1'b0, 17'h00000, 8'h00, 1'b0, 10'd0,    6'b000000, 4'd9},
    {1'b1, 17'h1FF80, 8'h00, 1'b0, 10'd0,    6'b000001, 4'd3}, // R3 high locked
    {1'b0, 17'h00000, 8'h00, 1'b1, 10'd1023, 6'b010001, 4'd5}, // R5
    {1'b0, 17'h00000, 8'h00, 1'b1, 10'd960,  6'b010001, 4'd5}, // R5 edge
    {1'b0, 17'h00000, 8'h00, 1'b1, 10'd959,  6'b100001, 4'd8}, // R8 outside
    {1'b0, 17'h00000, 8'h00, 1'b1, 10'd0,    6'b100001, 4'd8}, // R8 low open
    {1'b1, 17'h05555, 8'hAA, 1'b0, 10'd0,    6'b000001, 4'd7},
    {1'b1, 17'h02AAA, 8'h55, 1'b0, 10'd0,    6'b000001, 4'd7},
    {1'b1, 17'h05555, 8'h80, 1'b0, 10'd0,    6'b000001, 4'd7},
    {1'b1, 17'h05555, 8'hAA, 1'b0, 10'd0,    6'b000001, 4'd7},
    {1'b1, 17'h02AAA, 8'h55, 1'b0, 10'd0,    6'b000001, 4'd7},
    {1'b1, 17'h05555, 8'h10, 1'b0, 10'd0,    6'b000101, 4'd7}, // R7 refused
    {1'b1, 17'h05555, 8'hAA, 1'b0, 10'd0,    6'b000001, 4'd3},
    {1'b1, 17'h02AAA, 8'h55, 1'b0, 10'd0,    6'b000001, 4'd3},
    {1'b1, 17'h05555, 8'h80, 1'b0, 10'd0,    6'b000001, 4'd3},
    {1'b1, 17'h05555, 8'hAA, 1'b0, 10'd0,    6'b000001, 4'd3},
    {1'b1, 17'h02AAA, 8'h55, 1'b0, 10'd0,    6'b000001, 4'd3},
    {1'b1, 17'h05555, 8'h40, 1'b0, 10'd0,    6'b000001, 4'd3},
    {1'b1, 17'h0A000, 8'h00, 1'b0, 10'd0,    6'b000001, 4'd3}, // R3 middle address
    {1'b1, 17'h05555, 8'hAA, 1'b0, 10'd0,    6'b000001, 4'd6},
    {1'b1, 17'h02AAA, 8'h55, 1'b0, 10'd0,    6'b000001, 4'd6},
    {1'b1, 17'h05555, 8'h80, 1'b0, 10'd0,    6'b000001, 4'd6},
    {1'b1, 17'h05555, 8'hAA, 1'b0, 10'd0,    6'b000001, 4'd6},
    {1'b1, 17'h02AAA, 8'h55, 1'b0, 10'd0,    6'b000001, 4'd6},
    {1'b1, 17'h05555, 8'h40, 1'b0, 10'd0,    6'b000001, 4'd6},
    {1'b1, 17'h01234, 8'h01, 1'b0, 10'd0,    6'b000001, 4'd6}, // R6 bad final data
    {1'b1, 17'h05555, 8'hAA, 1'b0, 10'd0,    6'b000001, 4'd3},
    {1'b1, 17'h02AAA, 8'h55, 1'b0, 10'd0,    6'b000001, 4'd3},
    {1'b1, 17'h05555, 8'h80, 1'b0, 10'd0,    6'b000001, 4'd3},
    {1'b1, 17'h05555, 8'hAA, 1'b0, 10'd0,    6'b000001, 4'd3},
    {1'b1, 17'h02AAA, 8'h55, 1'b0, 10'd0,    6'b000001, 4'd3},
    {1'b1, 17'h05555, 8'h40, 1'b0, 10'd0,    6'b000001, 4'd3},
    {1'b1, 17'h01234, 8'h00, 1'b0, 10'd0,    6'b000011, 4'd3}, // R3 low locked
    {1'b0, 17'h00000, 8'h00, 1'b1, 10'd63,   6'b010011, 4'd5}, // R5 low edge
    {1'b0, 17'h00000, 8'h00, 1'b1, 10'd64,   6'b100011, 4'd5}  // R5 just outside
  };

  function automatic logic [5:0] outs();
    return {prog_grant, prog_deny, erase_grant, erase_deny, lock_lo, lock_hi};
  endfunction

  task automatic chk(input string tag, input logic [5:0] act, input logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic drive(input logic we, input logic [16:0] a, input logic [7:0] d,
                       input logic pr, input logic [9:0] sec);
    wr_en = we; wr_addr = a; wr_data = d; prog_req = pr; prog_sector = sec;
    @(negedge clk);
    wr_en = 1'b0; prog_req = 1'b0;
  endtask

  task automatic do_reset(input logic lo, input logic hi);
    @(negedge clk);
    rst_n = 1'b0; nv_lock_lo = lo; nv_lock_hi = hi;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; nv_lock_lo = 1'b0; nv_lock_hi = 1'b0; wr_en = 1'b0;
    wr_addr = '0; wr_data = '0; prog_req = 1'b0; prog_sector = '0;
    do_reset(1'b0, 1'b0);
    chk("R1 reset state", outs(), 6'b000000);

    do_reset(1'b0, 1'b1);
    chk("R2 preset high region", outs(), 6'b000001);
    nv_lock_hi = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 lock kept after preset drops", outs(), 6'b000001);
    drive(1'b0, 17'h0, 8'h0, 1'b1, 10'd1000);
    chk("R2 preset lock denies", outs(), 6'b010001);
    do_reset(1'b1, 1'b0);
    nv_lock_lo = 1'b0;
    chk("R2 preset low region", outs(), 6'b000010);
    do_reset(1'b0, 1'b0);
    chk("R1 reset clears locks", outs(), 6'b000000);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].we, VECS[i].a, VECS[i].d, VECS[i].pr, VECS[i].sec);
      chk($sformatf("R%0d row %0d", VECS[i].rq, i), outs(), VECS[i].ex);
    end

    drive(1'b0, 17'h0, 8'h0, 1'b1, 10'd500);
    chk("R4 grant pulse", outs(), 6'b100011);
    @(negedge clk);
    chk("R4 pulse one cycle", outs(), 6'b000011);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule